// File: doc/BRIEF.md
# Multislope rundown sequencer

This block sequences the rundown phase of a multislope integrating A/D converter. One clock cycle is one converter time step (one tick), and 30 ticks form a ramp. On a start request the block runs five fixed-length windows, T1 to T5. In each window it selects one reference current for the integrator. The magnitude drops by a factor of ten from window to window, except from T1 to T2, and the sign alternates. The block watches the integrator comparator and removes the current on the next half-ramp boundary after a crossing. It then selects no current for the rest of the window, so the total rundown time never changes.

The final window begins with the smallest negative current. After that current crosses, the block alternates the smallest positive and negative currents in 5-tick units until the window ends. For each of the first five current steps it reports how many ramps the current needed to cross. It also raises a per-window overrange bit when no crossing came in time. A one-cycle done pulse marks the end of the run.

Top module: `multislope_rundown_seq`

## Requirements
- R1: `sel_o` is one-hot at all times. Bit 0 means no current, bit 1 is S-4, bit 2 is S+4, bit 3 is S-3, bit 4 is S+2, bit 5 is S-1 and bit 6 is S+1. While idle, bit 0 is selected.
- R2: A crossing means `cmp_i`=1 while S-4, S-3 or S-1 is selected, and `cmp_i`=0 while S+4, S+2 or S+1 is selected. In T1 to T4, and in the first segment of T5, a crossing observed at window position p removes the current from position ceil((p+1)/15)*15.
- R3: The window after start holds S-4 and lasts 3 ramps (90 ticks). Then come S+4 for 3 ramps, S-3 for 7 ramps, S+2 for 7 ramps and S-1 for T5_RAMPS ramps (default 8). Window lengths do not depend on the comparator. Position 0 of T1 is the cycle after `start_i` is sampled high.
- R4: In T1 to T4, once the current is removed, no current is selected until the window ends, and `cmp_i` has no effect.
- R5: If `resid_neg_i` is low when start is sampled, S-4 is held in T1 for exactly positions 0 to 14 whatever `cmp_i` does, and the T1 count is 1.
- R6: In T5, from the removal position of the first S-1 segment, S+1 is selected. Each following segment alternates S+1 and S-1. A crossing at position p switches to the other current from position ceil((p+1)/5)*5.
- R7: The count for a window is ceil(q/30), where q is the position at which the current was removed. A current never removed in its window counts that window's full ramp total. The outputs `cnt_n4_o`, `cnt_p4_o`, `cnt_n3_o`, `cnt_p2_o` and `cnt_n1_o` hold the counts of T1 to T5 until the next start.
- R8: `ovr_o[k]` (bit 0 for T1 up to bit 4 for T5) is set when the window's first current saw no crossing, including its last cycle. It stays set until the next start clears it.
- R9: `done_o` is high for exactly the one cycle after the last T5 cycle, and the block is then idle. `start_i` has no effect while a run is in progress.
- R10: During reset, `sel_o` selects no current, `done_o` is low, and all counts and overrange bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | tick clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | begin a rundown when idle |
| cmp_i | input | 1 | integrator comparator, 1 = above zero |
| resid_neg_i | input | 1 | residual sign at start, 1 = negative |
| sel_o | output | 7 | one-hot current select |
| cnt_n4_o | output | CNT_W | S-4 ramp count |
| cnt_p4_o | output | CNT_W | S+4 ramp count |
| cnt_n3_o | output | CNT_W | S-3 ramp count |
| cnt_p2_o | output | CNT_W | S+2 ramp count |
| cnt_n1_o | output | CNT_W | first S-1 segment ramp count |
| ovr_o | output | 5 | sticky overrange per window |
| done_o | output | 1 | one-cycle end-of-rundown pulse |

## Verification
The assertions check on every cycle the rules that hold at any instant. Removals land only on half-ramp ticks and dither switches only on 5-tick ticks. A removed current stays off, and a window advances only on its last cycle. The positive-residual current is gone by tick 15, counts stay within their caps, and done lasts one cycle. Only the bench scenarios can show the exact removal position for a given crossing and the resulting counts. The same holds for the overrange bits at the window edges, the alternation order in the dither, and the run being unaffected by a start request mid-run.

// File: rtl/rd_pkg.sv
package rd_pkg;
  typedef enum logic [2:0] {
    W_IDLE = 3'd0, W_T1 = 3'd1, W_T2 = 3'd2, W_T3 = 3'd3, W_T4 = 3'd4, W_T5 = 3'd5
  } win_e;

  typedef enum logic [2:0] {
    CS_OFF = 3'd0, CS_N4 = 3'd1, CS_P4 = 3'd2, CS_N3 = 3'd3,
    CS_P2 = 3'd4, CS_N1 = 3'd5, CS_P1 = 3'd6
  } cur_e;

  localparam int NUM_CUR = 7;
  localparam int NUM_WIN = 5;

  typedef enum logic [1:0] {D_FIRST = 2'd0, D_POS = 2'd1, D_NEG = 2'd2} t5_e;

  function automatic logic cur_is_pos(cur_e c);
    return (c == CS_P4) || (c == CS_P2) || (c == CS_P1);
  endfunction
endpackage

// File: rtl/rd_timebase.sv
module rd_timebase #(
  parameter int POS_W    = 8,
  parameter int HALF_CYC = 15,
  parameter int DITH_CYC = 5,
  parameter int CNT_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [POS_W-1:0] len_i,
  output logic [POS_W-1:0] pos_o,
  output logic             half_end_o,
  output logic             dith_end_o,
  output logic             win_last_o,
  output logic [CNT_W-1:0] ramps_next_o
);
  localparam int HW       = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int DW       = (DITH_CYC > 1) ? $clog2(DITH_CYC) : 1;
  localparam int RAMP_CYC = 2 * HALF_CYC;

  logic [POS_W-1:0] pos_q;
  logic [HW-1:0]    half_q;
  logic             odd_q;
  logic [DW-1:0]    dith_q;
  logic [CNT_W-1:0] ramps_q;
  logic             ramp_first;

  assign ramp_first   = (half_q == '0) && !odd_q;
  assign half_end_o   = (half_q == HW'(HALF_CYC - 1));
  assign dith_end_o   = (dith_q == DW'(DITH_CYC - 1));
  assign win_last_o   = (pos_q == len_i - POS_W'(1));
  assign ramps_next_o = ramps_q + CNT_W'(ramp_first);
  assign pos_o        = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      half_q  <= '0;
      odd_q   <= 1'b0;
      dith_q  <= '0;
      ramps_q <= '0;
    end else if (clr_i) begin
      pos_q   <= '0;
      half_q  <= '0;
      odd_q   <= 1'b0;
      dith_q  <= '0;
      ramps_q <= '0;
    end else if (run_i) begin
      pos_q   <= pos_q + POS_W'(1);
      ramps_q <= ramps_next_o;
      if (half_end_o) begin
        half_q <= '0;
        odd_q  <= !odd_q;
      end else begin
        half_q <= half_q + HW'(1);
      end
      dith_q <= dith_end_o ? '0 : dith_q + DW'(1);
    end
  end

  // ramp counter and position counter are kept separately; they must agree
  a_r3_ramp_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_first |-> ((int'(pos_q) % RAMP_CYC) == 0));
  a_r6_dith_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dith_end_o |-> ((int'(pos_q) % DITH_CYC) == DITH_CYC - 1));
endmodule

// File: rtl/rd_xdet.sv
module rd_xdet import rd_pkg::*; (
  input  cur_e cur_i,
  input  logic cmp_i,
  output logic cross_o
);
  // negative currents ramp the integrator up, positive ones down
  always_comb begin
    if (cur_i == CS_OFF) cross_o = 1'b0;
    else if (cur_is_pos(cur_i)) cross_o = !cmp_i;
    else cross_o = cmp_i;
  end
endmodule

// File: rtl/rd_cur_dec.sv
module rd_cur_dec import rd_pkg::*; #(
  parameter int N = NUM_CUR
) (
  input  cur_e         cur_i,
  output logic [N-1:0] onehot_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign onehot_o[i] = (int'(cur_i) == i);
  end
endmodule

// File: rtl/multislope_rundown_seq.sv
module multislope_rundown_seq import rd_pkg::*; #(
  parameter int T12_RAMPS = 3,
  parameter int T34_RAMPS = 7,
  parameter int T5_RAMPS  = 8,
  parameter int HALF_CYC  = 15,
  parameter int DITH_CYC  = 5,
  localparam int MAX_RAMPS = (T5_RAMPS > T34_RAMPS)
                           ? ((T5_RAMPS > T12_RAMPS) ? T5_RAMPS : T12_RAMPS)
                           : ((T34_RAMPS > T12_RAMPS) ? T34_RAMPS : T12_RAMPS),
  localparam int CNT_W = $clog2(MAX_RAMPS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               cmp_i,
  input  logic               resid_neg_i,
  output logic [NUM_CUR-1:0] sel_o,
  output logic [CNT_W-1:0]   cnt_n4_o,
  output logic [CNT_W-1:0]   cnt_p4_o,
  output logic [CNT_W-1:0]   cnt_n3_o,
  output logic [CNT_W-1:0]   cnt_p2_o,
  output logic [CNT_W-1:0]   cnt_n1_o,
  output logic [NUM_WIN-1:0] ovr_o,
  output logic               done_o
);
  localparam int RAMP_CYC = 2 * HALF_CYC;
  localparam int LEN12    = T12_RAMPS * RAMP_CYC;
  localparam int LEN34    = T34_RAMPS * RAMP_CYC;
  localparam int LEN5     = T5_RAMPS * RAMP_CYC;
  localparam int MAX_LEN  = MAX_RAMPS * RAMP_CYC;
  localparam int POS_W    = $clog2(MAX_LEN + 1);

  win_e win_q;
  t5_e  t5_q;
  logic on_q, xed_q, neg_q, done_q;

  logic [POS_W-1:0] pos, len_sel;
  logic [CNT_W-1:0] ramps_next, cap_sel;
  logic half_end, dith_end, win_last;
  logic start_go, run, clr, cross_now;
  logic brief, dither, bnd, rm_go;
  logic cnt_wr, ovr_set;
  logic [CNT_W-1:0] cnt_val;
  logic [2:0] widx;
  cur_e cur_win, cur_act;
  logic [NUM_WIN-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_WIN-1:0] ovr_q;

  // window table
  always_comb begin
    cur_win = CS_OFF;
    len_sel = POS_W'(LEN12);
    cap_sel = CNT_W'(T12_RAMPS);
    unique case (win_q)
      W_T1: cur_win = CS_N4;
      W_T2: cur_win = CS_P4;
      W_T3: begin
        cur_win = CS_N3;
        len_sel = POS_W'(LEN34);
        cap_sel = CNT_W'(T34_RAMPS);
      end
      W_T4: begin
        cur_win = CS_P2;
        len_sel = POS_W'(LEN34);
        cap_sel = CNT_W'(T34_RAMPS);
      end
      W_T5: begin
        cur_win = (t5_q == D_POS) ? CS_P1 : CS_N1;
        len_sel = POS_W'(LEN5);
        cap_sel = CNT_W'(T5_RAMPS);
      end
      default: cur_win = CS_OFF;
    endcase
  end

  assign cur_act  = on_q ? cur_win : CS_OFF;
  assign start_go = (win_q == W_IDLE) && start_i;
  assign run      = (win_q != W_IDLE);
  assign clr      = start_go || (run && win_last);
  assign widx     = 3'(win_q) - 3'd1;

  assign brief  = (win_q == W_T1) && !neg_q;
  assign dither = (win_q == W_T5) && (t5_q != D_FIRST);
  assign bnd    = dither ? dith_end : half_end;
  assign rm_go  = on_q && bnd && (brief || xed_q || cross_now);

  // the first current of each window reports a count, at removal or at window end
  assign cnt_wr  = run && on_q && !dither && (win_last || rm_go);
  assign cnt_val = win_last ? cap_sel : ramps_next;
  assign ovr_set = run && win_last && on_q && !dither && !brief && !xed_q && !cross_now;

  rd_timebase #(
    .POS_W(POS_W), .HALF_CYC(HALF_CYC), .DITH_CYC(DITH_CYC), .CNT_W(CNT_W)
  ) u_tb (
    .clk_i, .rst_ni,
    .clr_i       (clr),
    .run_i       (run),
    .len_i       (len_sel),
    .pos_o       (pos),
    .half_end_o  (half_end),
    .dith_end_o  (dith_end),
    .win_last_o  (win_last),
    .ramps_next_o(ramps_next)
  );

  rd_xdet u_xdet (.cur_i(cur_act), .cmp_i, .cross_o(cross_now));

  rd_cur_dec #(.N(NUM_CUR)) u_dec (.cur_i(cur_act), .onehot_o(sel_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= W_IDLE;
      t5_q   <= D_FIRST;
      on_q   <= 1'b0;
      xed_q  <= 1'b0;
      neg_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_go) begin
        win_q <= W_T1;
        on_q  <= 1'b1;
        xed_q <= 1'b0;
        t5_q  <= D_FIRST;
        neg_q <= resid_neg_i;
      end else if (run) begin
        if (win_last) begin
          xed_q <= 1'b0;
          t5_q  <= D_FIRST;
          if (win_q == W_T5) begin
            win_q  <= W_IDLE;
            on_q   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            win_q <= win_e'(3'(win_q) + 3'd1);
            on_q  <= 1'b1;
          end
        end else if (rm_go) begin
          xed_q <= 1'b0;
          if (dither) t5_q <= (t5_q == D_POS) ? D_NEG : D_POS;
          else if (win_q == W_T5) t5_q <= D_POS;
          else on_q <= 1'b0;
        end else if (cross_now) begin
          xed_q <= 1'b1;
        end
      end
    end
  end

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_res
    localparam int CAP_K = (k < 2) ? T12_RAMPS : ((k < 4) ? T34_RAMPS : T5_RAMPS);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[k] <= '0;
        ovr_q[k] <= 1'b0;
      end else if (start_go) begin
        cnt_q[k] <= '0;
        ovr_q[k] <= 1'b0;
      end else if (widx == 3'(k)) begin
        if (cnt_wr) cnt_q[k] <= cnt_val;
        if (ovr_set) ovr_q[k] <= 1'b1;
      end
    end

    a_r7_cnt_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q[k] <= CNT_W'(CAP_K));
  end

  assign cnt_n4_o = cnt_q[0];
  assign cnt_p4_o = cnt_q[1];
  assign cnt_n3_o = cnt_q[2];
  assign cnt_p2_o = cnt_q[3];
  assign cnt_n1_o = cnt_q[4];
  assign ovr_o    = ovr_q;
  assign done_o   = done_q;

  a_r2_rm_on_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(on_q) && !on_q && (win_q != W_IDLE) && ($past(win_q) == win_q))
    |-> $past(half_end));
  a_r4_stays_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((win_q != W_IDLE) && (win_q != W_T5) && ($past(win_q) == win_q) && !$past(on_q))
    |-> !on_q);
  a_r5_brief_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((win_q == W_T1) && !neg_q && (pos == POS_W'(HALF_CYC))) |-> !on_q);
  a_r6_dither_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(win_q) == W_T5) && (win_q == W_T5) && ($past(t5_q) != D_FIRST)
     && (t5_q != $past(t5_q))) |-> $past(dith_end));
  a_r3_adv_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(win_q) != W_IDLE) && (win_q != $past(win_q))) |-> $past(win_last));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r9_done_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> ($past(win_q) == W_T5));
endmodule

// File: tb/multislope_rundown_seq_tb_top.sv
module multislope_rundown_seq_tb_top;
  localparam int T12 = 3, T34 = 7, T5R = 8, HC = 15, DC = 5, RC = 30, CW = 4;
  localparam logic [6:0] S_OFF = 7'h01, S_N4 = 7'h02, S_P4 = 7'h04, S_N3 = 7'h08,
                         S_P2 = 7'h10, S_N1 = 7'h20, S_P1 = 7'h40;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmp = 1'b0, rneg = 1'b0;
  logic [6:0] sel;
  logic [CW-1:0] c_n4, c_p4, c_n3, c_p2, c_n1;
  logic [4:0] ovr;
  logic done;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  multislope_rundown_seq #(
    .T12_RAMPS(T12), .T34_RAMPS(T34), .T5_RAMPS(T5R), .HALF_CYC(HC), .DITH_CYC(DC)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp), .resid_neg_i(rneg),
    .sel_o(sel), .cnt_n4_o(c_n4), .cnt_p4_o(c_p4), .cnt_n3_o(c_n3), .cnt_p2_o(c_p2),
    .cnt_n1_o(c_n1), .ovr_o(ovr), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int ceil_div(int a, int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int win_len(int k);
    return (k < 2) ? T12 * RC : ((k < 4) ? T34 * RC : T5R * RC);
  endfunction

  function automatic logic [6:0] win_cur(int k);
    case (k)
      0: return S_N4;
      1: return S_P4;
      2: return S_N3;
      3: return S_P2;
      default: return S_N1;
    endcase
  endfunction

  // comparator level meaning "not yet crossed" for a current
  function automatic logic nc(logic [6:0] c);
    return !((c == S_N4) || (c == S_N3) || (c == S_N1));
  endfunction

  task automatic run_case(input bit neg, input int cp0, input int cp1, input int cp2,
                          input int cp3, input int cp4, input int dmin, input int dmax,
                          input bit poke);
    int cp[5];
    int off[5];
    int cnt_e[5];
    bit ov_e[5];
    logic [6:0] cur_seg;
    int seg_start, dly, exp_sw;
    int cnt_a[5];
    cp = '{cp0, cp1, cp2, cp3, cp4};
    for (int k = 0; k < 5; k++) begin
      if (k == 0 && !neg) begin
        off[k] = HC;
        ov_e[k] = 1'b0;
      end else if (cp[k] >= win_len(k)) begin
        off[k] = win_len(k);
        ov_e[k] = 1'b1;
      end else begin
        off[k] = ceil_div(cp[k] + 1, HC) * HC;
        ov_e[k] = 1'b0;
      end
      cnt_e[k] = ceil_div(off[k], RC);
    end
    @(negedge clk);
    rneg = neg;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cur_seg = S_N1;
    seg_start = 0;
    dly = 1;
    exp_sw = -1;
    for (int k = 0; k < 5; k++) begin
      for (int p = 0; p < win_len(k); p++) begin
        logic [6:0] ex;
        start = poke && ($urandom_range(0, 7) == 0);  // R9: ignored mid-run
        if (k < 4 || p < off[4]) begin
          ex = (p < off[k]) ? win_cur(k) : S_OFF;
          if (k == 0 && !neg) chk(sel == ex, "R5 brief S-4 window", sel, ex);
          else if (p == 0) chk(sel == ex, "R3 window start current", sel, ex);
          else if (p < off[k]) chk(sel == ex, "R2 current held until removal", sel, ex);
          else chk(sel == ex, "R4 no current after removal", sel, ex);
          if (k == 0 && !neg) cmp = 1'($urandom_range(0, 1));
          else if (p < cp[k]) cmp = nc(win_cur(k));
          else if (p < off[k]) cmp = !nc(win_cur(k));
          else cmp = 1'($urandom_range(0, 1));
        end else begin
          if (p == off[4]) begin
            chk(sel == S_P1, "R6 dither starts with S+1", sel, S_P1);
            cur_seg = S_P1;
            seg_start = p;
            dly = $urandom_range(dmin, dmax);
            exp_sw = -1;
          end else if (p == exp_sw) begin
            ex = (cur_seg == S_P1) ? S_N1 : S_P1;
            chk(sel == ex, "R6 dither switch position", sel, ex);
            cur_seg = ex;
            seg_start = p;
            dly = $urandom_range(dmin, dmax);
            exp_sw = -1;
          end else begin
            chk(sel == cur_seg, "R6 dither segment held", sel, cur_seg);
          end
          cmp = (p - seg_start >= dly) ? !nc(cur_seg) : nc(cur_seg);
          if (p - seg_start == dly) exp_sw = ceil_div(p + 1, DC) * DC;
        end
        @(negedge clk);
      end
    end
    start = 1'b0;
    chk(done == 1'b1, "R9 done after T5", done, 1);
    chk(sel == S_OFF, "R1 idle selects no current", sel, S_OFF);
    cnt_a = '{int'(c_n4), int'(c_p4), int'(c_n3), int'(c_p2), int'(c_n1)};
    for (int k = 0; k < 5; k++) begin
      chk(cnt_a[k] == cnt_e[k], "R7 ramp count", cnt_a[k], cnt_e[k]);
      chk(ovr[k] == ov_e[k], "R8 overrange bit", ovr[k], ov_e[k]);
    end
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", done, 0);
    chk(sel == S_OFF, "R1 idle after done", sel, S_OFF);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(sel == S_OFF, "R10 reset select", sel, S_OFF);
    chk(done == 1'b0, "R10 reset done", done, 0);
    chk(ovr == 5'd0, "R10 reset overrange", ovr, 0);
    chk(c_n4 == 0 && c_p4 == 0 && c_n3 == 0 && c_p2 == 0 && c_n1 == 0,
        "R10 reset counts", c_n4, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel == S_OFF, "R1 idle without start", sel, S_OFF);
    run_case(1'b1, 0, 0, 0, 0, 0, 1, 1, 1'b0);
    run_case(1'b1, 14, 15, 29, 30, 44, 2, 6, 1'b0);
    run_case(1'b0, 5, 89, 209, 210, 300, 3, 9, 1'b1);
    run_case(1'b1, 90, 0, 100, 7, 0, 1, 12, 1'b1);
    run_case(1'b1, 59, 60, 180, 195, 239, 4, 4, 1'b0);
    for (int i = 0; i < 10; i++) begin
      run_case(1'($urandom_range(0, 1)),
               $urandom_range(0, 99), $urandom_range(0, 99),
               $urandom_range(0, 229), $urandom_range(0, 229),
               $urandom_range(0, 259), 1, $urandom_range(1, 12), 1'b1);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule